// File: doc/BRIEF.md
# Oversampled Serial Receiver with Idle-Line Watch

This block takes an asynchronous serial line and recovers characters from it. A one-cycle strobe arrives at sixteen times the bit rate. The block looks for a falling edge and confirms the start bit. Each bit is then judged by a two-of-three vote taken near the middle of the bit. At the middle of the stop bit the finished character moves into a holding register, and the receive-full flag rises.

Five sticky status flags report the outcome of reception: receive-full, overrun, noise, framing error and idle line. A single read strobe clears all five at once. The interrupt output combines receive-full and idle, and each has its own enable. A word-length select chooses between the base width and one extra data bit. While the receiver enable is low, the line is not watched at all.

Top module: `serial_rx_idle`

## Requirements
- R1: After a falling edge, the line is sampled on the 8th, 9th and 10th tick of the start bit, counting the edge tick as the 1st. If two or more of these samples are high, the start is treated as false and the receiver goes back to looking for a falling edge. No character results from a false start.
- R2: Data bits arrive least significant first. Each bit takes the majority of its three samples. With `long_word`=0 a frame carries 8 data bits and `rx_data[8]` reads 0. With `long_word`=1 it carries 9 data bits, and the 9th bit is placed in `rx_data[8]`.
- R3: The character moves into the holding register on the tick that takes the third sample of the stop bit. `flag_full` rises on that clock edge.
- R4: `flag_noise` is loaded with a character when the three samples of any of its bits (start, data or stop) are not all equal. Samples taken outside the voting window have no effect on it.
- R5: `flag_frm` is loaded high with a character whose stop-bit majority is low.
- R6: When a character completes while `flag_full` is set and no read occurs in that cycle, `flag_ovr` sets. The new character is dropped, and `rx_data`, `flag_noise` and `flag_frm` keep their values.
- R7: `flag_idle` sets when the line has been sampled high on consecutive ticks for one full frame: 160 ticks with 8-bit words, 176 with 9-bit words. This happens only if a character with a high stop bit has completed since the idle flag last set. Each such character allows `flag_idle` to set only once.
- R8: `rd_strobe` clears all five flags. If a character completes in the same cycle, it is accepted as if the holding register were empty. An idle event in the same cycle wins over the clear.
- R9: `irq` is high whenever (`rx_ie` and `flag_full`) or (`idle_ie` and `flag_idle`) holds.
- R10: While `rx_en` is low, any frame in progress is abandoned and no samples are taken. `rx_data` reads zero, and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input, idles high |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| long_word | input | 1 | 0: 8 data bits, 1: 9 data bits |
| rx_ie | input | 1 | Interrupt enable for receive-full |
| idle_ie | input | 1 | Interrupt enable for idle line |
| rd_strobe | input | 1 | Holding-register read; clears all flags |
| rx_data | output | 9 | Last accepted character, zero while disabled |
| flag_full | output | 1 | Holding register full |
| flag_ovr | output | 1 | Character lost to overrun |
| flag_noise | output | 1 | Sample disagreement in the held character |
| flag_frm | output | 1 | Stop bit sampled low in the held character |
| flag_idle | output | 1 | Idle line seen after a valid character |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is the idle flag's arming, because it is invisible at the ports. To observe that a flag did *not* set, the bench must first use up the arming with a long high stretch and clear the flag. It then holds the line high for more than a frame and checks that the flag stays low. After that it sends a character with a low stop bit and repeats the long high stretch, expecting the flag to stay low again. Only a later clean character should let the flag rise. Noise is reached by flipping the line for a single tick inside the voting window, and, for contrast, for a single tick outside it.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // ticks per bit and first voting phase (0-based phase within a bit)
  localparam int OVS     = 16;
  localparam int VOTE_PH = OVS / 2 - 1;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

  // ticks in one frame: start + data + stop
  function automatic int frame_ticks(input logic long_word, input int base_bits);
    return (base_bits + 2 + int'(long_word)) * OVS;
  endfunction
endpackage

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int BASE_BITS = 8,
  localparam int DW = BASE_BITS + 1,
  localparam int BW = $clog2(DW + 2),
  localparam int PW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          line,
  input  logic          long_word,
  output logic          char_done,
  output logic          char_stop,
  output logic          char_noise,
  output logic [DW-1:0] char_data
);
  logic [PW-1:0] ph_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          busy_q, prev_hi_q, s_a_q, s_b_q, nacc_q;
  logic [BW-1:0] stop_idx;
  logic          at_vote, vote, split;

  assign stop_idx   = long_word ? BW'(DW + 1) : BW'(DW);
  assign at_vote    = busy_q && (ph_q == PW'(VOTE_PH + 2));
  assign vote       = maj3(s_a_q, s_b_q, line);
  assign split      = split3(s_a_q, s_b_q, line);
  assign char_done  = en && tick && at_vote && (bit_q == stop_idx);
  assign char_stop  = vote;
  assign char_noise = nacc_q | split;
  assign char_data  = long_word ? sh_q : (sh_q >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      busy_q    <= 1'b0;
      prev_hi_q <= 1'b0;
      s_a_q     <= 1'b0;
      s_b_q     <= 1'b0;
      nacc_q    <= 1'b0;
    end else if (!en) begin
      busy_q    <= 1'b0;
      prev_hi_q <= 1'b0;
    end else if (tick) begin
      prev_hi_q <= line;
      if (!busy_q) begin
        if (!line && prev_hi_q) begin
          busy_q <= 1'b1;
          ph_q   <= PW'(1);
          bit_q  <= '0;
          nacc_q <= 1'b0;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
        if (ph_q == PW'(OVS - 1)) bit_q <= bit_q + 1'b1;
        if (ph_q == PW'(VOTE_PH)) s_a_q <= line;
        if (ph_q == PW'(VOTE_PH + 1)) s_b_q <= line;
        if (at_vote) begin
          nacc_q <= nacc_q | split;
          if (bit_q == '0) begin
            if (vote) busy_q <= 1'b0;
          end else if (bit_q == stop_idx) begin
            busy_q <= 1'b0;
          end else begin
            sh_q <= {vote, sh_q[DW-1:1]};
          end
        end
      end
    end
  end

  // a frame only opens on a low line sample
  assert_fall_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(!line));

  // a disabled receiver holds no frame
  assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_q);
endmodule

// File: rtl/srx_idle.sv
module srx_idle
  import srx_pkg::*;
#(
  parameter int BASE_BITS = 8,
  localparam int DW = BASE_BITS + 1,
  localparam int CW = $clog2((DW + 2) * OVS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic line,
  input  logic long_word,
  input  logic arm,
  output logic idle_hit
);
  logic [CW-1:0] run_q, span;
  logic          armed_q;

  assign span     = CW'(frame_ticks(long_word, BASE_BITS));
  assign idle_hit = en && tick && line && armed_q && (run_q == span - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (!en) run_q <= '0;
      else if (tick) begin
        if (!line) run_q <= '0;
        else if (run_q < span) run_q <= run_q + 1'b1;
      end
      if (idle_hit) armed_q <= 1'b0;
      else if (arm) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_idle.sv
module serial_rx_idle
  import srx_pkg::*;
#(
  parameter int BASE_BITS = 8,
  localparam int DW = BASE_BITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          long_word,
  input  logic          rx_ie,
  input  logic          idle_ie,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_data,
  output logic          flag_full,
  output logic          flag_ovr,
  output logic          flag_noise,
  output logic          flag_frm,
  output logic          flag_idle,
  output logic          irq
);
  logic          char_done, char_stop, char_noise, idle_hit;
  logic [DW-1:0] char_data, data_q;
  logic          full_eff, take, spill;

  srx_frame #(.BASE_BITS(BASE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .line(rx_line),
    .long_word(long_word), .char_done(char_done), .char_stop(char_stop),
    .char_noise(char_noise), .char_data(char_data)
  );

  srx_idle #(.BASE_BITS(BASE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .line(rx_line),
    .long_word(long_word), .arm(char_done && char_stop), .idle_hit(idle_hit)
  );

  // a read in the same cycle frees the holding register first
  assign full_eff = flag_full && !rd_strobe;
  assign take     = char_done && !full_eff;
  assign spill    = char_done && full_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      flag_full  <= 1'b0;
      flag_ovr   <= 1'b0;
      flag_noise <= 1'b0;
      flag_frm   <= 1'b0;
      flag_idle  <= 1'b0;
    end else begin
      flag_full <= take || full_eff;
      flag_ovr  <= spill || (flag_ovr && !rd_strobe);
      flag_idle <= idle_hit || (flag_idle && !rd_strobe);
      if (take) begin
        data_q     <= char_data;
        flag_noise <= char_noise;
        flag_frm   <= !char_stop;
      end else if (rd_strobe) begin
        flag_noise <= 1'b0;
        flag_frm   <= 1'b0;
      end
    end
  end

  assign rx_data = rx_en ? data_q : '0;
  assign irq     = (rx_ie && flag_full) || (idle_ie && flag_idle);

  assert_full_from_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_full) |-> $past(char_done));

  assert_ovr_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && flag_full && !rd_strobe) |=> (flag_ovr && $stable(data_q)));

  assert_idle_from_watch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_idle) |-> $past(idle_hit));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done && !idle_hit) |=> (!flag_full && !flag_ovr && !flag_idle));
endmodule

// File: tb/serial_rx_idle_bench.sv
`timescale 1ns/1ps
module serial_rx_idle_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1, tick16 = 1'b0, rx_en = 1'b0, long_word = 1'b0;
  logic       rx_ie = 1'b0, idle_ie = 1'b0, rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic       flag_full, flag_ovr, flag_noise, flag_frm, flag_idle, irq;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_rx_idle u_serial_rx_idle (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16), .rx_en(rx_en),
    .long_word(long_word), .rx_ie(rx_ie), .idle_ie(idle_ie), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .flag_full(flag_full), .flag_ovr(flag_ovr),
    .flag_noise(flag_noise), .flag_frm(flag_frm), .flag_idle(flag_idle), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  bit m_busy, m_prev, m_armed, m_nacc;
  bit m_full, m_ovr, m_noise, m_frm, m_idle;
  int m_pos, m_hrun, m_s0, m_s1, m_data;
  int m_bits[9];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_prev = 0; m_armed = 0; m_nacc = 0;
      m_full = 0; m_ovr = 0; m_noise = 0; m_frm = 0; m_idle = 0;
      m_pos = 0; m_hrun = 0; m_s0 = 0; m_s1 = 0; m_data = 0;
    end else begin
      bit ev_done, ev_idle, ev_stop, ev_noise;
      int nd, cd;
      ev_done = 0; ev_idle = 0; ev_stop = 0; ev_noise = 0; cd = 0;
      nd = long_word ? 9 : 8;
      if (!rx_en) begin
        m_busy = 0; m_prev = 0; m_hrun = 0;
      end else if (tick16) begin
        if (rx_line) begin
          if (m_hrun < (nd + 2) * 16) begin
            m_hrun++;
            if (m_hrun == (nd + 2) * 16 && m_armed) begin ev_idle = 1; m_armed = 0; end
          end
        end else m_hrun = 0;
        if (!m_busy) begin
          if (!rx_line && m_prev) begin m_busy = 1; m_pos = 1; m_nacc = 0; end
        end else begin
          int ph, bi, ones;
          bit v;
          ph = m_pos % 16; bi = m_pos / 16;
          if (ph == 7) m_s0 = int'(rx_line);
          if (ph == 8) m_s1 = int'(rx_line);
          if (ph == 9) begin
            ones = m_s0 + m_s1 + int'(rx_line);
            v = (ones >= 2);
            if (ones == 1 || ones == 2) m_nacc = 1;
            if (bi == 0) begin
              if (v) m_busy = 0;
            end else if (bi <= nd) begin
              m_bits[bi-1] = int'(v);
            end else begin
              ev_done = 1; ev_stop = v; ev_noise = m_nacc; m_busy = 0;
              if (v) m_armed = 1;
              for (int k = 0; k < nd; k++) cd += m_bits[k] << k;
            end
          end
          m_pos++;
        end
        m_prev = rx_line;
      end
      if (rd_strobe) begin m_full = 0; m_ovr = 0; m_noise = 0; m_frm = 0; m_idle = 0; end
      if (ev_done) begin
        if (m_full) m_ovr = 1;
        else begin m_data = cd; m_full = 1; m_noise = ev_noise; m_frm = !ev_stop; end
      end
      if (ev_idle) m_idle = 1;
    end
  end

  task automatic chk(input string what, input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("rx_data", "R2", int'(rx_data), rx_en ? m_data : 0);
      chk("flag_full", "R3", int'(flag_full), int'(m_full));
      chk("flag_noise", "R4", int'(flag_noise), int'(m_noise));
      chk("flag_frm", "R5", int'(flag_frm), int'(m_frm));
      chk("flag_ovr", "R6", int'(flag_ovr), int'(m_ovr));
      chk("flag_idle", "R7", int'(flag_idle), int'(m_idle));
      chk("irq", "R9", int'(irq), int'((rx_ie && m_full) || (idle_ie && m_idle)));
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  // ---------------- stimulus ----------------
  task automatic tk(input logic lv);
    @(posedge clk); #1; rx_line = lv; tick16 = 1'b1;
    @(posedge clk); #1; tick16 = 1'b0;
  endtask

  task automatic hi(input int n);
    for (int i = 0; i < n; i++) tk(1'b1);
  endtask

  task automatic rd_pulse();
    @(posedge clk); #1; rd_strobe = 1'b1;
    @(posedge clk); #1; rd_strobe = 1'b0;
  endtask

  // gbit/gtick: one inverted tick inside the frame (gbit < 0 for none)
  task automatic send(input logic [8:0] val, input int nd, input logic stop_lv,
                      input int gbit, input int gtick);
    for (int b = 0; b < nd + 2; b++) begin
      logic lvl;
      lvl = (b == 0) ? 1'b0 : (b <= nd) ? val[b-1] : stop_lv;
      for (int t = 0; t < 16; t++) tk((b == gbit && t == gtick) ? ~lvl : lvl);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("reset full", "R3", int'(flag_full), 0);
    chk("reset idle", "R7", int'(flag_idle), 0);
    chk("disabled data", "R10", int'(rx_data), 0);

    rx_en = 1'b1; rx_ie = 1'b1;
    hi(20);
    send(9'h0A5, 8, 1'b1, -1, 0); hi(4);
    chk("data A5", "R2", int'(rx_data), 'h0A5);
    chk("full after char", "R3", int'(flag_full), 1);
    chk("irq on full", "R9", int'(irq), 1);
    rd_pulse();
    chk("full cleared", "R8", int'(flag_full), 0);

    // one flipped sample inside the voting window of data bit 3
    send(9'h03C, 8, 1'b1, 3, 8); hi(4);
    chk("noise in window", "R4", int'(flag_noise), 1);
    chk("data despite noise", "R4", int'(rx_data), 'h03C);
    rd_pulse();
    // flip outside the window: no noise
    send(9'h05A, 8, 1'b1, 2, 2); hi(4);
    chk("noise outside window", "R4", int'(flag_noise), 0);
    rd_pulse();

    // false start: 5 low ticks only
    for (int i = 0; i < 5; i++) tk(1'b0);
    hi(40);
    chk("false start no char", "R1", int'(flag_full), 0);
    // start with two of three window samples high
    for (int i = 0; i < 16; i++) tk((i == 8 || i == 9) ? 1'b1 : 1'b0);
    hi(200);
    chk("start vote high", "R1", int'(flag_full), 0);

    // idle: armed by earlier clean characters; the high stretch above consumed it
    chk("idle after frame", "R7", int'(flag_idle), 1);
    idle_ie = 1'b1; rx_ie = 1'b0;
    @(posedge clk); #1;
    chk("irq on idle", "R9", int'(irq), 1);
    rd_pulse();
    hi(200);
    chk("idle not rearmed", "R7", int'(flag_idle), 0);

    // framing error: stop low, does not arm idle
    send(9'h081, 8, 1'b0, -1, 0); hi(200);
    chk("framing", "R5", int'(flag_frm), 1);
    chk("no idle after bad stop", "R7", int'(flag_idle), 0);
    rd_pulse();
    send(9'h044, 8, 1'b1, -1, 0); hi(180);
    chk("idle after clean char", "R7", int'(flag_idle), 1);
    rd_pulse();

    // overrun
    send(9'h011, 8, 1'b1, -1, 0); hi(3);
    send(9'h022, 8, 1'b1, -1, 0); hi(3);
    chk("overrun", "R6", int'(flag_ovr), 1);
    chk("overrun keeps data", "R6", int'(rx_data), 'h011);
    rd_pulse();
    chk("read clears ovr", "R8", int'(flag_ovr), 0);
    chk("read clears full", "R8", int'(flag_full), 0);

    // nine-bit word
    long_word = 1'b1; hi(4);
    send(9'h1C3, 9, 1'b1, -1, 0); hi(4);
    chk("nine bit data", "R2", int'(rx_data), 'h1C3);
    rd_pulse();
    long_word = 1'b0; hi(4);
    send(9'h0FF, 8, 1'b1, -1, 0); hi(4);
    chk("eight bit top zero", "R2", int'(rx_data), 'h0FF);

    // disable mid-frame: flags hold, data hidden
    for (int i = 0; i < 16; i++) tk(1'b0);
    hi(20);
    @(posedge clk); #1 rx_en = 1'b0;
    @(posedge clk); #1;
    chk("disabled data zero", "R10", int'(rx_data), 0);
    chk("disabled full held", "R10", int'(flag_full), 1);
    for (int i = 0; i < 40; i++) tk(i[0]);
    rx_en = 1'b1; hi(30);
    chk("reenabled data", "R10", int'(rx_data), 'h0FF);
    chk("reenabled noise", "R10", int'(flag_noise), 0);

    repeat (4) @(posedge clk);
    summary();
  end
endmodule